// File: doc/BRIEF.md
# Interrupt and Timer Unit with Custom Instructions

This unit sits beside the execute stage of a small 32-bit RISC-V style core and carries out six custom instructions that share the custom0 major opcode. The core hands over the instruction word with a valid strobe, the value of the rs1 operand and the current program counter. The unit returns a write-back value for rd, a program counter redirect, a stall while the core waits for an interrupt, and a one-cycle pulse that marks interrupt entry. Every output is registered, so a result appears in the cycle after the instruction is presented.

The unit holds four shadow q-registers, an interrupt mask, a pending bitmask and a countdown timer. On entry it saves the return address in q0 and the bitmask of the serviced sources in q1, then sends the core to a handler address 16 bytes above the reset address. It does not accept a nested interrupt until a return instruction runs. Pending bit 0 belongs to the timer. External line i sets pending bit i+1 on its rising level, so a pulse that lasts one cycle is still caught.

Top module: `irq_custom_unit`

## Requirements
- R1: Only a word with insn_valid high and bits 6:0 equal to 0001011 is executed. Bits 31:25 pick the operation (0 getq, 1 setq, 2 retirq, 3 maskirq, 4 waitirq, 5 timer). Bits 24:20 and 14:12 have no effect.
- R2: setq writes rs1_val into the q-register whose index is bits 8:7. getq returns the q-register whose index is bits 16:15 on rd_data with rd_we high, one cycle after the instruction.
- R3: maskirq loads the low IRQ_W bits of rs1_val into the mask, where a 1 blocks that source. It returns the previous mask on rd_data.
- R4: timer loads rs1_val into a down-counter and returns the counter's previous value. The counter falls by one each cycle while it is non-zero. Its step from 1 to 0 sets pending bit 0. Loading 0 stops it.
- R5: A rising level on ext_irq[i] sets pending bit i+1. The bit stays set after the line falls, until an entry services it.
- R6: When no handler is active and pending AND NOT mask is non-zero, the next output cycle shows irq_entry and pc_redirect with pc_target = RESET_ADDR + 16. q0 receives cur_pc, q1 receives the serviced bits, and those bits are cleared from pending. Any instruction presented in that cycle is dropped.
- R7: While a handler is active, no further entry takes place.
- R8: retirq redirects to the value in q0 and ends the active handler.
- R9: waitirq returns the whole pending bitmask, masked bits included, on rd_data. If pending is zero, stall stays high with rd_we low until a bit is set, and the result follows one cycle later.
- R10: A custom0 word whose bits 31:25 are 6 or above pulses illegal for one cycle. It writes nothing back and changes no state.
- R11: After reset every output is low, no handler is active, the timer is stopped, pending is empty and the mask is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn_word | input | 32 | Instruction word |
| rs1_val | input | 32 | Value of the rs1 operand |
| cur_pc | input | 32 | Address of the presented instruction; becomes the return address on entry |
| ext_irq | input | IRQ_W-1 | External interrupt lines, synchronous to clk |
| rd_we | output | 1 | Write-back strobe for rd |
| rd_data | output | 32 | Write-back value |
| pc_redirect | output | 1 | Program counter redirect strobe |
| pc_target | output | 32 | Redirect address |
| stall | output | 1 | Core must hold while waitirq waits |
| irq_entry | output | 1 | One-cycle pulse on interrupt entry |
| illegal | output | 1 | One-cycle pulse for an unknown custom0 operation |

## Verification
The assertions assume that ext_irq is synchronous to clk and that the core presents no instruction while stall is high. They also assume that an instruction issued in the cycle of an entry will be issued again after the return. The stimulus drives every input half a cycle away from the clock edge, issues nothing while stall is high, and leaves a free cycle wherever an entry is expected. Under these conditions the dropped-instruction case never hides a check.

// File: rtl/irq_unit_pkg.sv
`timescale 1ns/1ps
package irq_unit_pkg;
  localparam int DATA_W = 32;
  localparam int QREG_N = 4;
  localparam logic [6:0] CUSTOM0_OPC = 7'b0001011;

  typedef enum logic [2:0] {
    OP_GETQ  = 3'd0,
    OP_SETQ  = 3'd1,
    OP_RETQ  = 3'd2,
    OP_MASK  = 3'd3,
    OP_WAIT  = 3'd4,
    OP_TIMER = 3'd5,
    OP_NONE  = 3'd6,
    OP_BAD   = 3'd7
  } cop_e;
endpackage

// File: rtl/cust_decode.sv
`timescale 1ns/1ps
module cust_decode
  import irq_unit_pkg::*;
(
  input  logic        valid,
  input  logic [31:0] insn,
  output cop_e        op,
  output logic [1:0]  q_src,
  output logic [1:0]  q_dst
);
  // funct3, rs2 and the upper index bits carry no meaning here
  logic unused_fields;
  assign unused_fields = ^{insn[24:17], insn[14:9]};

  assign q_src = insn[16:15];
  assign q_dst = insn[8:7];

  always_comb begin
    op = OP_NONE;
    if (valid && insn[6:0] == CUSTOM0_OPC) begin
      case (insn[31:25])
        7'd0:    op = OP_GETQ;
        7'd1:    op = OP_SETQ;
        7'd2:    op = OP_RETQ;
        7'd3:    op = OP_MASK;
        7'd4:    op = OP_WAIT;
        7'd5:    op = OP_TIMER;
        default: op = OP_BAD;
      endcase
    end
  end
endmodule

// File: rtl/irq_timer.sv
`timescale 1ns/1ps
module irq_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         fire
);
  logic [W-1:0] cnt_q;

  assign count = cnt_q;
  assign fire  = !load && (cnt_q == W'(1));

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assert_load_R4: assert property (@(posedge clk) disable iff (rst)
    load |=> count == $past(load_val));
  assert_fire_zero_R4: assert property (@(posedge clk) disable iff (rst)
    fire |=> count == '0);
  assert_stopped_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && count == '0) |=> count == '0);
endmodule

// File: rtl/irq_pending.sv
`timescale 1ns/1ps
module irq_pending #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-2:0] ext_irq,
  input  logic         timer_fire,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-2:0] ext_q;
  logic [N-1:0] set_vec;
  logic [N-1:0] pend_q;

  assign set_vec = {ext_irq & ~ext_q, timer_fire};
  assign pend    = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q  <= '0;
      pend_q <= '0;
    end else begin
      ext_q  <= ext_irq;
      pend_q <= (pend_q & ~clr) | set_vec;
    end
  end

  generate
    for (genvar i = 0; i < N - 1; i++) begin : g_line_chk
      assert_latch_rise_R5: assert property (@(posedge clk) disable iff (rst)
        (ext_irq[i] && !ext_q[i]) |=> pend[i+1]);
      assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (pend[i+1] && !clr[i+1]) |=> pend[i+1]);
    end
  endgenerate

  assert_timer_set_R4: assert property (@(posedge clk) disable iff (rst)
    timer_fire |=> pend[0]);
endmodule

// File: rtl/irq_custom_unit.sv
`timescale 1ns/1ps
module irq_custom_unit
  import irq_unit_pkg::*;
#(
  parameter int          IRQ_W      = 8,
  parameter logic [31:0] RESET_ADDR = 32'h0000_0000,
  parameter logic [31:0] VEC_OFFSET = 32'h0000_0010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_valid,
  input  logic [31:0]       insn_word,
  input  logic [31:0]       rs1_val,
  input  logic [31:0]       cur_pc,
  input  logic [IRQ_W-2:0]  ext_irq,
  output logic              rd_we,
  output logic [31:0]       rd_data,
  output logic              pc_redirect,
  output logic [31:0]       pc_target,
  output logic              stall,
  output logic              irq_entry,
  output logic              illegal
);
  localparam logic [31:0] VEC_ADDR = RESET_ADDR + VEC_OFFSET;

  cop_e              op;
  logic [1:0]        q_src;
  logic [1:0]        q_dst;
  logic [IRQ_W-1:0]  pend;
  logic [IRQ_W-1:0]  mask_q;
  logic [IRQ_W-1:0]  serviced;
  logic [IRQ_W-1:0]  clr;
  logic              in_handler;
  logic              waiting;
  logic              take_irq;
  logic              exec;
  logic              tmr_load;
  logic              tmr_fire;
  logic [DATA_W-1:0] tmr_count;
  logic [DATA_W-1:0] qreg [QREG_N];

  cust_decode u_dec (
    .valid (insn_valid),
    .insn  (insn_word),
    .op    (op),
    .q_src (q_src),
    .q_dst (q_dst)
  );

  assign serviced = pend & ~mask_q;
  assign take_irq = !in_handler && (serviced != '0);
  assign exec     = !waiting && !take_irq;
  assign tmr_load = exec && (op == OP_TIMER);
  assign clr      = take_irq ? serviced : '0;

  irq_timer #(.W(DATA_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (rs1_val),
    .count    (tmr_count),
    .fire     (tmr_fire)
  );

  irq_pending #(.N(IRQ_W)) u_pend (
    .clk        (clk),
    .rst        (rst),
    .ext_irq    (ext_irq),
    .timer_fire (tmr_fire),
    .clr        (clr),
    .pend       (pend)
  );

  // shadow bank: no reset, software treats q2/q3 as scratch
  always_ff @(posedge clk) begin
    if (take_irq) begin
      qreg[0] <= cur_pc;
      qreg[1] <= DATA_W'(serviced);
    end else if (exec && op == OP_SETQ) begin
      qreg[q_dst] <= rs1_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q      <= '1;
      in_handler  <= 1'b0;
      waiting     <= 1'b0;
      rd_we       <= 1'b0;
      rd_data     <= '0;
      pc_redirect <= 1'b0;
      pc_target   <= '0;
      irq_entry   <= 1'b0;
      illegal     <= 1'b0;
    end else begin
      rd_we       <= 1'b0;
      pc_redirect <= 1'b0;
      irq_entry   <= 1'b0;
      illegal     <= 1'b0;
      if (take_irq) begin
        in_handler  <= 1'b1;
        waiting     <= 1'b0;
        irq_entry   <= 1'b1;
        pc_redirect <= 1'b1;
        pc_target   <= VEC_ADDR;
      end else if (waiting) begin
        if (pend != '0) begin
          waiting <= 1'b0;
          rd_we   <= 1'b1;
          rd_data <= DATA_W'(pend);
        end
      end else begin
        case (op)
          OP_GETQ: begin
            rd_we   <= 1'b1;
            rd_data <= qreg[q_src];
          end
          OP_RETQ: begin
            in_handler  <= 1'b0;
            pc_redirect <= 1'b1;
            pc_target   <= qreg[0];
          end
          OP_MASK: begin
            mask_q  <= rs1_val[IRQ_W-1:0];
            rd_we   <= 1'b1;
            rd_data <= DATA_W'(mask_q);
          end
          OP_WAIT: begin
            if (pend != '0) begin
              rd_we   <= 1'b1;
              rd_data <= DATA_W'(pend);
            end else begin
              waiting <= 1'b1;
            end
          end
          OP_TIMER: begin
            rd_we   <= 1'b1;
            rd_data <= tmr_count;
          end
          OP_BAD:  illegal <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign stall = waiting;

  assert_no_nest_R7: assert property (@(posedge clk) disable iff (rst)
    irq_entry |=> !irq_entry);
  assert_entry_vec_R6: assert property (@(posedge clk) disable iff (rst)
    irq_entry |-> (pc_redirect && pc_target == VEC_ADDR && !rd_we));
  assert_stall_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    stall |-> !rd_we);
  assert_wait_done_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> (rd_we || irq_entry));
  assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!rd_we && !pc_redirect));
  assert_illegal_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    (illegal && !$past(insn_valid)) |-> 1'b0);
  assert_reset_mask_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '1 && !in_handler && !stall));
endmodule

// File: tb/irq_custom_unit_tb_top.sv
`timescale 1ns/1ps
module irq_custom_unit_tb_top;
  localparam int IRQ_W = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_valid = 1'b0;
  logic [31:0] insn_word = '0;
  logic [31:0] rs1_val = '0;
  logic [31:0] cur_pc = 32'h240;
  logic [IRQ_W-2:0] ext_irq = '0;
  logic        rd_we, pc_redirect, stall, irq_entry, illegal;
  logic [31:0] rd_data, pc_target;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_custom_unit #(.IRQ_W(IRQ_W)) dut_i (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
    .rs1_val(rs1_val), .cur_pc(cur_pc), .ext_irq(ext_irq),
    .rd_we(rd_we), .rd_data(rd_data), .pc_redirect(pc_redirect),
    .pc_target(pc_target), .stall(stall), .irq_entry(irq_entry),
    .illegal(illegal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input int f7, input int rs1f, input int rdf, input int junk);
    return {f7[6:0], junk[4:0], rs1f[4:0], junk[7:5], rdf[4:0], 7'b0001011};
  endfunction

  // called at a falling edge; returns at the next falling edge with results visible
  task automatic issue_raw(input logic v, input logic [31:0] w, input logic [31:0] r);
    insn_valid = v; insn_word = w; rs1_val = r;
    @(negedge clk);
    insn_valid = 1'b0; insn_word = '0; rs1_val = '0;
  endtask

  task automatic issue(input logic [31:0] w, input logic [31:0] r);
    issue_raw(1'b1, w, r);
  endtask

  function automatic logic [31:0] qpat(input int q);
    return 32'h1357_9BDF + q * 32'h1111_1111;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R9 watchdog actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 rd_we", {31'b0, rd_we}, 32'd0);
    chk("R11 pc_redirect", {31'b0, pc_redirect}, 32'd0);
    chk("R11 stall", {31'b0, stall}, 32'd0);
    chk("R11 irq_entry", {31'b0, irq_entry}, 32'd0);
    chk("R11 illegal", {31'b0, illegal}, 32'd0);

    // R3 mask write and readback; R11 mask is all ones
    issue(enc(3, 2, 1, 0), 32'h0000_005A);
    chk("R11 mask reset", rd_data, 32'hFF);
    chk("R3 rd_we", {31'b0, rd_we}, 32'd1);
    issue(enc(3, 2, 1, 8'hE7), 32'hFFFF_FFFF);
    chk("R3 old mask", rd_data, 32'h5A);
    issue(enc(3, 2, 1, 0), 32'h0000_00FF);
    chk("R3 mask upper bits dropped", rd_data, 32'hFF);

    // R2 q-register sweep with junk in funct3/rs2 and upper index bits (R1)
    for (int j = 0; j < 4; j++) begin
      for (int q = 0; q < 4; q++)
        issue(enc(1, 5'h1C | j, (j << 2) | q, j * 8'h5B), qpat(q) ^ j);
      for (int q = 0; q < 4; q++) begin
        issue(enc(0, (j << 2) | q, 5'h1F, 8'hFF - j), 32'hDEAD_0000);
        chk("R2 getq", rd_data, qpat(q) ^ j);
        chk("R2 rd_we", {31'b0, rd_we}, 32'd1);
      end
    end
    // R1 wrong opcode and invalid strobe have no effect
    w = enc(1, 0, 2, 0); w[6:0] = 7'b0001010;
    issue(w, 32'hDEAD_BEEF);
    chk("R1 other opcode no writeback", {31'b0, rd_we}, 32'd0);
    issue_raw(1'b0, enc(1, 0, 2, 0), 32'hDEAD_BEEF);
    chk("R1 invalid no writeback", {31'b0, rd_we}, 32'd0);
    issue(enc(0, 2, 0, 0), 32'd0);
    chk("R1 q2 unchanged", rd_data, qpat(2) ^ 3);

    // R10 sweep of all unknown operation codes
    for (int f = 6; f < 128; f++) begin
      issue(enc(f, f & 31, 3, f), 32'hFFFF_FFFF);
      chk("R10 illegal pulse", {31'b0, illegal}, 32'd1);
      chk("R10 no writeback", {30'b0, rd_we, pc_redirect}, 32'd0);
    end
    chk("R10 pulse one cycle", {31'b0, illegal}, 32'd1);
    @(negedge clk);
    chk("R10 pulse ends", {31'b0, illegal}, 32'd0);
    issue(enc(0, 3, 0, 0), 32'd0);
    chk("R10 q3 unchanged", rd_data, qpat(3) ^ 3);
    issue(enc(3, 0, 0, 0), 32'h0000_00FF);
    chk("R10 mask unchanged", rd_data, 32'hFF);

    // R9 waitirq stalls, R5 one-cycle pulse on line 2 sets pending bit 3
    issue(enc(4, 0, 1, 0), 32'd0);
    chk("R9 stall", {31'b0, stall}, 32'd1);
    chk("R9 no writeback while stalled", {31'b0, rd_we}, 32'd0);
    ext_irq = 7'b000_0100;
    @(negedge clk);
    ext_irq = '0;
    chk("R9 still stalled", {31'b0, stall}, 32'd1);
    @(negedge clk);
    chk("R9 stall released", {31'b0, stall}, 32'd0);
    chk("R5 pending from pulse", rd_data, 32'h8);
    chk("R9 rd_we", {31'b0, rd_we}, 32'd1);
    repeat (3) @(negedge clk);
    issue(enc(4, 0, 1, 0), 32'd0);
    chk("R5 pending held", rd_data, 32'h8);

    // R4 timer readback, load 0 stops it
    issue(enc(5, 1, 1, 0), 32'd10);
    issue(enc(5, 1, 1, 0), 32'd0);
    chk("R4 old count", rd_data, 32'd10);
    issue(enc(5, 1, 1, 0), 32'd5);
    issue(enc(5, 1, 1, 0), 32'd0);
    chk("R4 old count 5", rd_data, 32'd5);
    repeat (10) @(negedge clk);
    issue(enc(4, 0, 1, 0), 32'd0);
    chk("R4 stopped timer sets nothing", rd_data, 32'h8);
    issue(enc(5, 1, 1, 0), 32'd100);
    repeat (7) @(negedge clk);
    issue(enc(5, 1, 1, 0), 32'd3);
    chk("R4 decrement", rd_data, 32'd93);
    repeat (4) @(negedge clk);
    issue(enc(4, 0, 1, 0), 32'd0);
    chk("R4 expiry sets bit 0", rd_data, 32'h9);

    // R6 entry on the timer source only
    issue(enc(3, 0, 0, 0), 32'h0000_00FE);
    chk("R6 no entry before mask change", {31'b0, irq_entry}, 32'd0);
    @(negedge clk);
    chk("R6 irq_entry", {31'b0, irq_entry}, 32'd1);
    chk("R6 redirect", {31'b0, pc_redirect}, 32'd1);
    chk("R6 vector", pc_target, 32'h10);
    issue(enc(0, 1, 0, 0), 32'd0);
    chk("R6 q1 serviced", rd_data, 32'h1);
    issue(enc(0, 0, 0, 0), 32'd0);
    chk("R6 q0 return pc", rd_data, 32'h240);
    issue(enc(4, 0, 1, 0), 32'd0);
    chk("R6 serviced bit cleared", rd_data, 32'h8);

    // R7 no nesting while the handler runs
    issue(enc(3, 0, 0, 0), 32'h0000_00F6);
    chk("R7 old mask", rd_data, 32'hFE);
    for (int k = 0; k < 3; k++) begin
      chk("R7 no nested entry", {31'b0, irq_entry}, 32'd0);
      @(negedge clk);
    end

    // R8 return, then re-entry for bit 3
    issue(enc(2, 0, 0, 0), 32'd0);
    chk("R8 redirect", {31'b0, pc_redirect}, 32'd1);
    chk("R8 target", pc_target, 32'h240);
    chk("R8 no entry same cycle", {31'b0, irq_entry}, 32'd0);
    cur_pc = 32'h380;
    @(negedge clk);
    chk("R6 re-entry", {31'b0, irq_entry}, 32'd1);
    issue(enc(0, 1, 0, 0), 32'd0);
    chk("R6 q1 second source", rd_data, 32'h8);
    issue(enc(3, 0, 0, 0), 32'h0000_00FF);
    issue(enc(2, 0, 0, 0), 32'd0);
    chk("R8 target second", pc_target, 32'h380);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 masked after return", {31'b0, irq_entry}, 32'd0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule